// File: doc/BRIEF.md
# Packed Day-Minute Real-Time Counter

This block keeps elapsed time in a single 28-bit word. The low field holds the minute of the day, the middle field holds a day count and the top field holds a small year count. A fast tick input passes through two divider stages. Together they produce one event per second. A seconds counter then turns every sixtieth such event into a one-minute advance of the packed word.

Day and minute rollovers are handled in binary, with no BCD digits. The minute field wraps after 1439. The day field, once it passes 365, drops back by 365 and carries into the year field.

An external agent can preset the whole word through a load strobe. The load changes only the word: the dividers and the seconds count keep their phase. The current word is always visible on an output port. A synchronous, active-high reset clears everything.

Top module: `day_minute_rtc`

## Requirements
- R1: A synchronous active-high reset clears the packed word, both divider stages and the seconds count; `time_o` reads 0 in the cycle after reset.
- R2: The first divider stage advances only in cycles where `tick_i` is 1, and wraps once every PRE1_DIV (default 128) ticks; idle cycles with `tick_i` low change nothing.
- R3: The second divider stage counts first-stage wraps and emits one second event every PRE2_DIV (default 32768) wraps, so one second equals PRE1_DIV*PRE2_DIV ticks.
- R4: The seconds count runs 0 to 59; the second event that finds it at 59 returns it to 0 and advances the packed word by one minute, so the word changes exactly on tick number 60*PRE1_DIV*PRE2_DIV after reset.
- R5: Minutes live in bits [11:0]; when a one-minute advance makes them exceed 1439, 1440 is subtracted and the day field gains one.
- R6: Days live in bits [23:12]; when a carry makes the day field exceed 365, 365 is subtracted (so 365 plus one becomes 1) and the year field gains one.
- R7: Years live in bits [27:24] and wrap from 15 to 0 without any other effect.
- R8: When `load_i` is 1, the word takes `load_val_i` at the next edge, even if a minute advance is due in that same cycle.
- R9: A load leaves the divider stages and the seconds count untouched, so the next minute advance keeps the phase set since reset.
- R10: Apart from reset, load and a minute advance, the packed word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Fast time-base tick, one count per cycle it is high |
| load_i | input | 1 | Preset strobe for the packed word |
| load_val_i | input | 28 | Value loaded: year [27:24], day [23:12], minute [11:0] |
| time_o | output | 28 | Current packed word, same field layout |

## Verification
The bench runs with small divider settings. With them, a minute takes 960 ticks, and the word is sampled one tick before and exactly at that tick. This separates a correct divide ratio from off-by-one chains.

Idle gaps with the tick low show whether the dividers are gated by the tick or by the clock. Preset words sit just under the minute, day and year limits. They show whether the wrap points are applied correctly, including the day step from 365 to 1 and the silent year wrap.

Loads placed mid-minute and on the exact tick of a minute advance show two things: that loading does not disturb the divider phase, and that the load wins over the advance.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int MIN_W   = 12;
  localparam int DAY_W   = 12;
  localparam int YEAR_W  = 4;
  localparam int TIME_W  = MIN_W + DAY_W + YEAR_W;
  localparam int DAY_LSB = MIN_W;
  localparam int YR_LSB  = MIN_W + DAY_W;
  localparam int MW1     = MIN_W + 1;
  localparam int DW1     = DAY_W + 1;

  typedef logic [TIME_W-1:0] rtc_word_t;

  function automatic logic [MIN_W-1:0] word_min(rtc_word_t w);
    return w[MIN_W-1:0];
  endfunction

  function automatic logic [DAY_W-1:0] word_day(rtc_word_t w);
    return w[YR_LSB-1:DAY_LSB];
  endfunction

  function automatic logic [YEAR_W-1:0] word_year(rtc_word_t w);
    return w[TIME_W-1:YR_LSB];
  endfunction

  // Advance the packed word by one minute, applying both rollover rules.
  function automatic rtc_word_t bump_minute(rtc_word_t w,
                                            int unsigned min_per_day,
                                            int unsigned day_max);
    logic [MW1-1:0]    m;
    logic [DW1-1:0]    d;
    logic [YEAR_W-1:0] y;
    m = {1'b0, word_min(w)} + 1'b1;
    d = {1'b0, word_day(w)};
    y = word_year(w);
    if (m > MW1'(min_per_day - 1)) begin
      m = m - MW1'(min_per_day);
      d = d + 1'b1;
    end
    if (d > DW1'(day_max)) begin
      d = d - DW1'(day_max);
      y = y + 1'b1;
    end
    return {y, d[DAY_W-1:0], m[MIN_W-1:0]};
  endfunction
endpackage

// File: rtl/rtc_mod_counter.sv
module rtc_mod_counter #(
  parameter int unsigned MOD = 128,
  localparam int unsigned W  = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic wrap
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] count;

  assign wrap = step && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= wrap ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/rtc_time_reg.sv
module rtc_time_reg
  import rtc_pkg::*;
#(
  parameter int unsigned MIN_PER_DAY = 1440,
  parameter int unsigned DAY_MAX     = 365
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  rtc_word_t load_val,
  input  logic      advance,
  output rtc_word_t time_q
);
  always_ff @(posedge clk) begin
    if (rst)          time_q <= '0;
    else if (load)    time_q <= load_val;
    else if (advance) time_q <= bump_minute(time_q, MIN_PER_DAY, DAY_MAX);
  end
endmodule

// File: rtl/day_minute_rtc.sv
module day_minute_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned PRE1_DIV    = 128,
  parameter int unsigned PRE2_DIV    = 32768,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned MIN_PER_DAY = 1440,
  parameter int unsigned DAY_MAX     = 365
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  output logic [TIME_W-1:0] time_o
);
  localparam int NSTAGE = 3;
  localparam int unsigned STAGE_MOD [NSTAGE] = '{PRE1_DIV, PRE2_DIV, SEC_PER_MIN};

  logic [NSTAGE:0] stage_step;
  logic pre_wrap;
  logic sec_evt;
  logic min_evt;

  assign stage_step[0] = tick_i;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    rtc_mod_counter #(.MOD(STAGE_MOD[i])) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .step (stage_step[i]),
      .wrap (stage_step[i+1])
    );
  end

  assign pre_wrap = stage_step[1];
  assign sec_evt  = stage_step[2];
  assign min_evt  = stage_step[3];

  rtc_time_reg #(.MIN_PER_DAY(MIN_PER_DAY), .DAY_MAX(DAY_MAX)) u_word (
    .clk      (clk),
    .rst      (rst),
    .load     (load_i),
    .load_val (load_val_i),
    .advance  (min_evt),
    .time_q   (time_o)
  );
endmodule

// File: rtl/day_minute_rtc_chk.sv
module day_minute_rtc_chk
  import rtc_pkg::*;
#(
  parameter int unsigned MIN_PER_DAY = 1440
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              load_i,
  input logic [TIME_W-1:0] load_val_i,
  input logic [TIME_W-1:0] time_o,
  input logic              pre_wrap,
  input logic              sec_evt,
  input logic              min_evt
);
  // R1: reset empties the word
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> time_o == '0);

  // R2: no tick, no first-stage wrap
  a_r2_tick_gates: assert property (@(posedge clk) disable iff (rst)
    !tick_i |-> !pre_wrap);

  // R3: a second event only coincides with a first-stage wrap
  a_r3_sec_needs_pre: assert property (@(posedge clk) disable iff (rst)
    sec_evt |-> pre_wrap);

  // R4: a minute advance only coincides with a second event
  a_r4_min_needs_sec: assert property (@(posedge clk) disable iff (rst)
    min_evt |-> sec_evt);

  // R5: below the wrap point an advance adds exactly one minute
  a_r5_minute_step: assert property (@(posedge clk) disable iff (rst)
    (min_evt && !load_i && (time_o[MIN_W-1:0] < MIN_W'(MIN_PER_DAY - 1)))
    |=> time_o[MIN_W-1:0] == $past(time_o[MIN_W-1:0]) + 1'b1);

  // R8: a load wins
  a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
    load_i |=> time_o == $past(load_val_i));

  // R10: nothing else moves the word
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !min_evt) |=> $stable(time_o));
endmodule

bind day_minute_rtc day_minute_rtc_chk #(.MIN_PER_DAY(MIN_PER_DAY)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_i     (tick_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .time_o     (time_o),
  .pre_wrap   (pre_wrap),
  .sec_evt    (sec_evt),
  .min_evt    (min_evt)
);

// File: tb/day_minute_rtc_test.sv
module day_minute_rtc_test;
  localparam int P1 = 4;
  localparam int P2 = 4;
  localparam int TPM = 60 * P1 * P2;   // ticks per minute = 960

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        load_i = 1'b0;
  logic [27:0] load_val_i = '0;
  logic [27:0] time_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  day_minute_rtc #(.PRE1_DIV(P1), .PRE2_DIV(P2)) uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
    .load_val_i(load_val_i), .time_o(time_o)
  );

  function automatic logic [27:0] mk(int y, int d, int m);
    return {y[3:0], d[11:0], m[11:0]};
  endfunction

  // Independent model of one minute step, field by field.
  function automatic logic [27:0] after_min(logic [27:0] w);
    int mn = int'(w[11:0]) + 1;
    int dy = int'(w[23:12]);
    int yr = int'(w[27:24]);
    if (mn >= 1440) begin mn -= 1440; dy += 1; end
    if (dy >= 366)  begin dy -= 365; yr = (yr + 1) % 16; end
    return mk(yr, dy, mn);
  endfunction

  task automatic check(string req, logic [27:0] exp);
    total++;
    if (time_o !== exp) begin
      bad++;
      $display("FAIL %s time_o=%h expected=%h", req, time_o, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic do_reset();
    rst = 1'b1; tick_i = 1'b0; load_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_ticks(int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [27:0] v);
    load_i = 1'b1; load_val_i = v;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic t_reset();
    run_ticks(37);
    load(mk(2, 9, 9));
    do_reset();
    check("R1 reset clears word", '0);
    run_ticks(TPM - 1);
    check("R1 counters cleared by reset (no early minute)", '0);
    run_ticks(1);
    check("R1 first minute after reset", mk(0, 0, 1));
  endtask

  task automatic t_cadence();
    do_reset();
    run_ticks(TPM - 1);
    check("R10 word holds before minute", '0);
    run_ticks(1);
    check("R4 minute on exact tick", mk(0, 0, 1));
    idle(200);
    check("R2 idle cycles do not count", mk(0, 0, 1));
    run_ticks(TPM - 1);
    check("R3 second divider ratio (not yet)", mk(0, 0, 1));
    run_ticks(1);
    check("R3 second divider ratio", mk(0, 0, 2));
  endtask

  task automatic t_minute_wrap();
    logic [27:0] w;
    do_reset();
    w = mk(0, 5, 100);
    load(w);
    check("R8 load value", w);
    run_ticks(TPM);
    check("R5 plain step", after_min(w));
    w = mk(1, 5, 1439);
    load(w);
    run_ticks(TPM);
    check("R5 minute wrap into day", after_min(w));
  endtask

  task automatic t_day_wrap();
    logic [27:0] w;
    do_reset();
    w = mk(3, 364, 1439);
    load(w);
    run_ticks(TPM);
    check("R6 day below limit", after_min(w));
    w = mk(3, 365, 1439);
    load(w);
    run_ticks(TPM);
    check("R6 day 365 goes to 1 with year carry", after_min(w));
  endtask

  task automatic t_year_wrap();
    logic [27:0] w;
    do_reset();
    w = mk(15, 365, 1439);
    load(w);
    run_ticks(TPM);
    check("R7 year wraps to 0", after_min(w));
  endtask

  task automatic t_load_priority();
    logic [27:0] w;
    do_reset();
    run_ticks(TPM - 1);
    w = mk(4, 200, 700);
    tick_i = 1'b1; load_i = 1'b1; load_val_i = w;
    @(negedge clk);
    tick_i = 1'b0; load_i = 1'b0;
    check("R8 load beats minute advance", w);
    run_ticks(TPM - 1);
    check("R9 phase kept after load (not yet)", w);
    run_ticks(1);
    check("R9 phase kept after load", after_min(w));
  endtask

  task automatic t_load_mid();
    logic [27:0] w;
    do_reset();
    run_ticks(500);
    w = mk(7, 30, 59);
    load(w);
    run_ticks(TPM - 501);
    check("R9 mid-minute load keeps dividers (not yet)", w);
    run_ticks(1);
    check("R9 mid-minute load keeps dividers", after_min(w));
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cadence();
    t_minute_wrap();
    t_day_wrap();
    t_year_wrap();
    t_load_priority();
    t_load_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, all requirements unresolved");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule